// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register file of a colour LCD controller. A host on a simple 32-bit bus, with a read strobe, a write strobe and a word-aligned byte address, programs four panel timing words, two frame base addresses (upper and lower panel), an interrupt mask and a control word. It reads back interrupt status in raw and masked form, reaches a 128-word palette window and a read-only identification window. Reads are combinational: data is valid in the same cycle as the read strobe. Writes take effect at the next rising clock edge.

From the stored words the block derives the signals the rest of the controller needs. The active column and row counts come from fields of the first two timing words. The display-enable flag, the pixel-depth code and the two endianness selects come from the control word. Interrupt events from the display pipeline set sticky status bits. Software clears them by writing ones to a clear register. The interrupt output is high while any unmasked status bit is set. Any bus write requests a full redraw through a one-cycle pulse. Accesses to holes in the map are flagged and have no effect.

Top module: `lcdc_regfile`

## Requirements
- R1: After a synchronous active-low reset, every stored register is zero, every palette word is zero, and `irq`, `disp_en`, `redraw_req` and `bus_err` are low.
- R2: Word offsets 0 to 3 (byte 0x00 to 0x0C) hold timing words 0 to 3, offset 4 (0x10) the upper base, offset 5 (0x14) the lower base, offset 6 (0x18) the mask and offset 7 (0x1C) control. Each reads back what was last written. The mask keeps only its low NUM_IRQ bits and reads the other bits as zero.
- R3: `act_cols` equals ((timing0 AND 0xFC) + 4) × 4, and `act_rows` equals (timing1 AND 0x3FF) + 1.
- R4: `disp_en` is high only when control bit 0 (enable) and bit 11 (power) are both 1. `depth_code` is control bits 3:1. `be_bytes` is control bit 9. `be_pixels` is control bit 10.
- R5: Offset 8 (0x20) reads the raw status and offset 9 (0x24) reads raw status AND mask. A high bit on `irq_event` sets the matching status bit at the next edge. `irq` is the OR of the masked status.
- R6: A write to offset 10 (0x28) clears every status bit whose written bit is 1. If an event sets the same bit in the same cycle, the event wins and the bit stays set.
- R7: Byte addresses 0xFE0 to 0xFFC read, one byte per word in the low 8 bits, the values 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order.
- R8: Byte addresses 0x200 to 0x3FC form 128 readable and writable palette words, indexed by address bits 8:2.
- R9: Offsets 11 (0x2C) and 12 (0x30) read back the current upper and lower base addresses.
- R10: Every cycle with `bus_wr` high is followed, in the next cycle, by exactly one cycle of `redraw_req` high.
- R11: A read of an address outside the readable set (offsets 0–9, 11, 12, the palette and the identification window) returns zero. A write outside the writable set (offsets 0–7, 10 and the palette) changes nothing. In both cases `bus_err` is high in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the read strobe, zero when no read |
| bus_err | output | 1 | Access to an unmapped address for that direction |
| irq_event | input | NUM_IRQ | Interrupt event pulses from the display pipeline |
| irq | output | 1 | Interrupt request |
| disp_en | output | 1 | Display enabled (enable and power both set) |
| depth_code | output | 3 | Pixel-depth code |
| be_bytes | output | 1 | Big-endian byte order select |
| be_pixels | output | 1 | Big-endian pixel order within bytes |
| act_cols | output | 11 | Active column count |
| act_rows | output | 11 | Active row count |
| base_upper | output | 32 | Upper panel frame base |
| base_lower | output | 32 | Lower panel frame base |
| redraw_req | output | 1 | One-cycle full-redraw request after a write |

## Verification
A corrupted stored word shows at the ports in the very next cycle. The derived outputs (`act_cols`, `act_rows`, `disp_en`, the depth and endianness selects, the base outputs) are continuous functions of the registers. A wrong status or mask bit shows on `irq` in the cycle after the event or write that exposes it, and on a read of offset 8 or 9. A stale palette word, or a decode that aliases one window onto another, shows only when that address is read. For that reason the stimulus reads back every window after writing it, and includes reads of the map's holes.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types of the LCD controller register file.
// Assumes a 4 KB register window addressed by a 12-bit byte address.
package lcdc_pkg;
    localparam int ADDR_W    = 12;
    localparam int WADDR_W   = ADDR_W - 2;
    localparam int DATA_W    = 32;
    localparam int PAL_DEPTH = 128;
    localparam int PAL_IW    = $clog2(PAL_DEPTH);
    localparam int PAL_WBASE = 'h200 >> 2;
    localparam int ID_WORDS  = 8;
    localparam int ID_WBASE  = 'hFE0 >> 2;
    localparam int DIM_W     = 11;

    // word offsets inside the register region
    localparam logic [3:0] OFS_TIM0   = 4'd0;
    localparam logic [3:0] OFS_TIM3   = 4'd3;
    localparam logic [3:0] OFS_UP     = 4'd4;
    localparam logic [3:0] OFS_LO     = 4'd5;
    localparam logic [3:0] OFS_MASK   = 4'd6;
    localparam logic [3:0] OFS_CTRL   = 4'd7;
    localparam logic [3:0] OFS_RAW    = 4'd8;
    localparam logic [3:0] OFS_MSK    = 4'd9;
    localparam logic [3:0] OFS_CLR    = 4'd10;
    localparam logic [3:0] OFS_CUR_UP = 4'd11;
    localparam logic [3:0] OFS_CUR_LO = 4'd12;

    // control bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_BEBYT = 9;
    localparam int CTL_BEPIX = 10;
    localparam int CTL_PWR   = 11;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_REG  = 2'd1,
        RGN_PAL  = 2'd2,
        RGN_ID   = 2'd3
    } rgn_e;

    // Identification byte for one word of the ID window.
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    id_byte = 8'h10;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/lcdc_decode.sv
`timescale 1ns/1ps
// Address decoder: splits a word address into region and index, and tells
// whether a read or a write to it is legal. Purely combinational.
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [WADDR_W-1:0] waddr,
    output rgn_e               rgn,
    output logic [3:0]         reg_idx,
    output logic [PAL_IW-1:0]  pal_idx,
    output logic [2:0]         id_idx,
    output logic               rd_ok,
    output logic               wr_ok
);
    // region select from the word address
    always_comb begin
        rgn = RGN_NONE;
        if (waddr <= WADDR_W'(OFS_CUR_LO))
            rgn = RGN_REG;
        else if (waddr >= WADDR_W'(PAL_WBASE) && waddr < WADDR_W'(PAL_WBASE + PAL_DEPTH))
            rgn = RGN_PAL;
        else if (waddr >= WADDR_W'(ID_WBASE))
            rgn = RGN_ID;
    end

    assign reg_idx = waddr[3:0];
    assign pal_idx = waddr[PAL_IW-1:0];
    assign id_idx  = waddr[2:0];

    // legality per direction
    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        case (rgn)
            RGN_REG: begin
                rd_ok = (reg_idx != OFS_CLR);
                wr_ok = (reg_idx <= OFS_CTRL) || (reg_idx == OFS_CLR);
            end
            RGN_PAL: begin
                rd_ok = 1'b1;
                wr_ok = 1'b1;
            end
            RGN_ID:  rd_ok = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lcdc_palette.sv
`timescale 1ns/1ps
// Palette storage: DEPTH words, one synchronous write port and one
// combinational read port. Cleared by reset.
module lcdc_palette #(
    parameter int DEPTH = 128,
    parameter int W     = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // write port with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/lcdc_irq.sv
`timescale 1ns/1ps
// Interrupt block: sticky status set by events, cleared by write-one-to-clear,
// a mask register and the OR-reduced interrupt request. Set wins over clear.
module lcdc_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    // mask register and sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            if (mask_we) mask <= wdata;
            status <= (status & ~clr_bits) | set_in;
        end
    end

    assign irq = |(status & mask);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_in == '0) |=> ((status & $past(wdata)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_in != '0) |=> ((status & $past(set_in)) == $past(set_in)));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && set_in == '0) |=> $stable(status));

    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((set_in != '0) || mask_we));
endmodule

// File: rtl/lcdc_regfile.sv
`timescale 1ns/1ps
// LCD controller register file (top). Holds timing, base, mask and control
// words; reaches palette, status and ID windows; derives geometry and mode
// outputs. Assumes word-aligned accesses and at most one strobe per cycle.
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int NUM_IRQ = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic [NUM_IRQ-1:0] irq_event,
    output logic               irq,
    output logic               disp_en,
    output logic [2:0]         depth_code,
    output logic               be_bytes,
    output logic               be_pixels,
    output logic [DIM_W-1:0]   act_cols,
    output logic [DIM_W-1:0]   act_rows,
    output logic [DATA_W-1:0]  base_upper,
    output logic [DATA_W-1:0]  base_lower,
    output logic               redraw_req
);
    localparam int NUM_TIM = 4;

    rgn_e              rgn;
    logic [3:0]        reg_idx;
    logic [PAL_IW-1:0] pal_idx;
    logic [2:0]        id_idx;
    logic              rd_ok, wr_ok;
    logic              wr_go;
    logic [DATA_W-1:0] tim [NUM_TIM];
    logic [DATA_W-1:0] ctrl;
    logic [DATA_W-1:0] pal_rdata;
    logic [NUM_IRQ-1:0] status, mask;

    lcdc_decode u_dec (
        .waddr   (bus_addr[ADDR_W-1:2]),
        .rgn     (rgn),
        .reg_idx (reg_idx),
        .pal_idx (pal_idx),
        .id_idx  (id_idx),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok)
    );

    assign wr_go = bus_wr && wr_ok;

    // timing words, one register each
    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
        always_ff @(posedge clk) begin
            if (!rst_n)
                tim[g] <= '0;
            else if (wr_go && rgn == RGN_REG && reg_idx == OFS_TIM0 + 4'(g))
                tim[g] <= bus_wdata;
        end
    end

    // base addresses and control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_upper <= '0;
            base_lower <= '0;
            ctrl       <= '0;
        end else if (wr_go && rgn == RGN_REG) begin
            if (reg_idx == OFS_UP)   base_upper <= bus_wdata;
            if (reg_idx == OFS_LO)   base_lower <= bus_wdata;
            if (reg_idx == OFS_CTRL) ctrl       <= bus_wdata;
        end
    end

    // redraw request one cycle after any write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) redraw_req <= 1'b0;
        else        redraw_req <= bus_wr;
    end

    lcdc_palette #(.DEPTH(PAL_DEPTH), .W(DATA_W)) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_go && rgn == RGN_PAL),
        .widx  (pal_idx),
        .wdata (bus_wdata),
        .ridx  (pal_idx),
        .rdata (pal_rdata)
    );

    lcdc_irq #(.N(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_in  (irq_event),
        .mask_we (wr_go && rgn == RGN_REG && reg_idx == OFS_MASK),
        .clr_we  (wr_go && rgn == RGN_REG && reg_idx == OFS_CLR),
        .wdata   (bus_wdata[NUM_IRQ-1:0]),
        .status  (status),
        .mask    (mask),
        .irq     (irq)
    );

    // derived geometry and mode outputs
    assign act_cols   = ({{(DIM_W-6){1'b0}}, tim[0][7:2]} + DIM_W'(1)) << 4;
    assign act_rows   = {{(DIM_W-10){1'b0}}, tim[1][9:0]} + DIM_W'(1);
    assign disp_en    = ctrl[CTL_EN] & ctrl[CTL_PWR];
    assign depth_code = ctrl[3:1];
    assign be_bytes   = ctrl[CTL_BEBYT];
    assign be_pixels  = ctrl[CTL_BEPIX];

    assign bus_err = (bus_rd && !rd_ok) || (bus_wr && !wr_ok);

    // read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && rd_ok) begin
            case (rgn)
                RGN_PAL: bus_rdata = pal_rdata;
                RGN_ID:  bus_rdata = {{(DATA_W-8){1'b0}}, id_byte(id_idx)};
                RGN_REG: begin
                    case (reg_idx)
                        OFS_UP, OFS_CUR_UP: bus_rdata = base_upper;
                        OFS_LO, OFS_CUR_LO: bus_rdata = base_lower;
                        OFS_MASK: bus_rdata = DATA_W'(mask);
                        OFS_CTRL: bus_rdata = ctrl;
                        OFS_RAW:  bus_rdata = DATA_W'(status);
                        OFS_MSK:  bus_rdata = DATA_W'(status & mask);
                        default:  if (reg_idx <= OFS_TIM3) bus_rdata = tim[reg_idx[1:0]];
                    endcase
                end
                default: ;
            endcase
        end
    end

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_err) |-> (bus_rdata == '0));

    assert_redraw_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redraw_req |-> $past(bus_wr));

    assert_en_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_en) |-> $past(bus_wr));

    assert_geom_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(act_cols) && $stable(act_rows)));
endmodule

// File: tb/lcdc_regfile_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the outputs each cycle.
module lcdc_regfile_tb_top;
    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [N-1:0] irq_event = '0;
    logic [31:0] bus_rdata, base_upper, base_lower;
    logic        bus_err, irq, disp_en, be_bytes, be_pixels, redraw_req;
    logic [2:0]  depth_code;
    logic [10:0] act_cols, act_rows;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    lcdc_regfile #(.NUM_IRQ(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_event(irq_event), .irq(irq), .disp_en(disp_en),
        .depth_code(depth_code), .be_bytes(be_bytes), .be_pixels(be_pixels),
        .act_cols(act_cols), .act_rows(act_rows), .base_upper(base_upper),
        .base_lower(base_lower), .redraw_req(redraw_req)
    );

    // reference model state
    longint m_tim [4];
    longint m_up, m_lo, m_ctrl, m_mask, m_stat;
    longint m_pal [128];
    bit     m_redraw;

    function automatic longint id_val(int i);
        longint t [8] = '{'h10, 'h11, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};
        return t[i];
    endfunction

    function automatic bit rd_legal(int w);
        return (w <= 9) || w == 11 || w == 12 || (w >= 128 && w < 256) || w >= 1016;
    endfunction

    function automatic bit wr_legal(int w);
        return (w <= 7) || w == 10 || (w >= 128 && w < 256);
    endfunction

    function automatic longint exp_rd(int w);
        if (!rd_legal(w)) return 0;
        if (w <= 3) return m_tim[w];
        if (w == 4 || w == 11) return m_up;
        if (w == 5 || w == 12) return m_lo;
        if (w == 6) return m_mask;
        if (w == 7) return m_ctrl;
        if (w == 8) return m_stat;
        if (w == 9) return m_stat & m_mask;
        if (w < 256) return m_pal[w - 128];
        return id_val(w - 1016);
    endfunction

    function automatic string rd_tag(int w);
        if (!rst_n) return "R1";
        if (!rd_legal(w)) return "R11";
        if (w <= 7) return "R2";
        if (w <= 9) return "R5";
        if (w <= 12) return "R9";
        if (w < 256) return "R8";
        return "R7";
    endfunction

    task automatic chk(input string tag, input string what, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // model update at every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_tim[i] = 0;
            for (int i = 0; i < 128; i++) m_pal[i] = 0;
            m_up = 0; m_lo = 0; m_ctrl = 0; m_mask = 0; m_stat = 0; m_redraw = 0;
        end else begin
            int w;
            longint clr;
            w = int'(bus_addr[11:2]);
            clr = 0;
            if (bus_wr && wr_legal(w)) begin
                if (w <= 3) m_tim[w] = bus_wdata;
                else if (w == 4) m_up = bus_wdata;
                else if (w == 5) m_lo = bus_wdata;
                else if (w == 6) m_mask = bus_wdata & ((1 << N) - 1);
                else if (w == 7) m_ctrl = bus_wdata;
                else if (w == 10) clr = bus_wdata & ((1 << N) - 1);
                else m_pal[w - 128] = bus_wdata;
            end
            m_stat = (m_stat & ~clr) | irq_event;
            m_redraw = bus_wr;
        end
    end

    // compare all outputs away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int w;
            string t1;
            w = int'(bus_addr[11:2]);
            t1 = rst_n ? "" : "R1";
            chk(rd_tag(w), "rdata", bus_rdata, bus_rd ? exp_rd(w) : 0);
            chk(rst_n ? "R11" : t1, "err",
                bus_err, (bus_rd && !rd_legal(w)) || (bus_wr && !wr_legal(w)));
            chk(rst_n ? "R5" : t1, "irq", irq, (m_stat & m_mask) != 0);
            chk(rst_n ? "R4" : t1, "disp_en", disp_en, m_ctrl[0] && m_ctrl[11]);
            chk(rst_n ? "R4" : t1, "depth", depth_code, (m_ctrl >> 1) & 7);
            chk(rst_n ? "R4" : t1, "be_bytes", be_bytes, m_ctrl[9]);
            chk(rst_n ? "R4" : t1, "be_pixels", be_pixels, m_ctrl[10]);
            chk(rst_n ? "R3" : t1, "cols", act_cols, ((m_tim[0] & 'hFC) + 4) * 4);
            chk(rst_n ? "R3" : t1, "rows", act_rows, (m_tim[1] & 'h3FF) + 1);
            chk(rst_n ? "R9" : t1, "base_upper", base_upper, m_up);
            chk(rst_n ? "R9" : t1, "base_lower", base_lower, m_lo);
            chk(rst_n ? "R10" : t1, "redraw", redraw_req, m_redraw);
        end
    end

    task automatic cyc(input bit rd, input bit wr, input logic [11:0] a,
                       input logic [31:0] d, input logic [N-1:0] ev);
        @(posedge clk); #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; irq_event = ev;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cyc(0, 1, a, d, '0);
    endtask

    task automatic rd(input logic [11:0] a);
        cyc(1, 0, a, '0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc(0, 0, 12'h000, 0, '0);
        // R2 / R3: timing words and geometry
        wr(12'h000, 32'h0000_00FF);
        wr(12'h004, 32'hFFFF_F405);
        rd(12'h000); rd(12'h004);
        wr(12'h000, 32'h0000_0003);
        wr(12'h004, 32'h0000_03FF);
        wr(12'h004, 32'h0000_0000);
        wr(12'h008, 32'hA5A5_5A5A);
        wr(12'h00C, 32'h1234_5678);
        for (int i = 0; i < 4; i++) rd(12'(i * 4));
        // R9: bases
        wr(12'h010, 32'h8000_1000);
        wr(12'h014, 32'h0004_2000);
        rd(12'h010); rd(12'h014); rd(12'h02C); rd(12'h030);
        // R4: control decode
        wr(12'h01C, 32'h0000_0001); rd(12'h01C);
        wr(12'h01C, 32'h0000_0800);
        wr(12'h01C, 32'h0000_0801);
        wr(12'h01C, 32'h0000_0E0B); rd(12'h01C);
        wr(12'h01C, 32'h0000_0200);
        // R5 / R6: interrupts
        wr(12'h018, 32'hFFFF_FF15); rd(12'h018);
        cyc(0, 0, 12'h000, 0, 5'h03);
        cyc(0, 0, 12'h000, 0, 5'h00);
        rd(12'h020); rd(12'h024);
        wr(12'h028, 32'h0000_0001);
        rd(12'h020);
        @(negedge clk); chk("R6", "clear one", bus_rdata, 32'h2);
        cyc(0, 1, 12'h028, 32'h0000_0002, 5'h02);
        rd(12'h020);
        @(negedge clk); chk("R6", "set wins", bus_rdata, 32'h2);
        cyc(0, 0, 12'h000, 0, 5'h10);
        rd(12'h024);
        wr(12'h028, 32'hFFFF_FFFF);
        rd(12'h020); rd(12'h024);
        // R8: palette
        wr(12'h200, 32'hDEAD_BEEF);
        wr(12'h3FC, 32'h0BAD_F00D);
        wr(12'h2A8, 32'h7FFF_7C1F);
        rd(12'h200); rd(12'h3FC); rd(12'h2A8); rd(12'h204);
        // R7: identification window
        for (int i = 0; i < 8; i++) rd(12'('hFE0 + i * 4));
        // R11: holes and illegal directions
        rd(12'h034); rd(12'h100); rd(12'h028); rd(12'h400); rd(12'hFDC);
        wr(12'h020, 32'h0000_001F); rd(12'h020);
        wr(12'h02C, 32'hFFFF_FFFF); rd(12'h02C);
        wr(12'h400, 32'h1111_1111); rd(12'h200);
        wr(12'hFE0, 32'h0000_0099); rd(12'hFE0);
        cyc(0, 0, 12'h000, 0, '0);
        // R1: reset again, idle outputs
        @(posedge clk); #1 rst_n = 1'b0;
        cyc(0, 0, 12'h000, 0, '0);
        #1 rst_n = 1'b1;
        rd(12'h01C); rd(12'h200);
        cyc(0, 0, 12'h000, 0, '0);
        @(negedge clk);
        @(posedge clk); #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule